// File: doc/BRIEF.md
# Two-Dimensional DMA Address Generator

This block produces the address stream for a two-dimensional memory transfer. A transfer is described by a start address, an inner (row) element count with a signed byte stride, and an outer row count with a second signed byte stride. Each address is offered on a valid/ready port and advances only when the consumer accepts it. Within a row the inner stride applies. When a row ends, the outer stride takes the place of the inner stride, so one descriptor can cover a contiguous scan, a sub-window inside a wider frame, or a scan that runs backwards.

The transfer starts on a rising edge of `enable`. All configuration is copied into the block at that moment. In stop mode the generator goes idle after the final element and sets `done`. In autobuffer mode it also sets `done`, then returns to the copied start address with both counts reloaded and keeps going. A zero count or a start address that is not aligned to the element size sets `error`, and the transfer does not start. The sticky flags are cleared by single-cycle clear pulses. Dropping `enable` stops the transfer at once.

Top module: `dma2d_addr_gen`

## Requirements
- R1: After reset, `addrValid`, `running`, `done` and `error` are all 0.
- R2: A rising edge of `enable` with a valid configuration sets `running` at the next clock edge, and the first address offered is `cfgStart`.
- R3: Within a row, each accepted address is followed by the previous address plus `cfgXModify`. `cfgXModify` is sign-extended from 16 bits, and the sum wraps modulo 2^32.
- R4: After the last element of a row is accepted, the next address is the previous address plus the sign-extended `cfgYModify`, and the inner count restarts.
- R5: While `addrValid` is 1 and `addrReady` is 0, `addrOut` holds its value.
- R6: In stop mode (`cfgAuto`=0), exactly `cfgXCount`×`cfgYCount` addresses are issued. At the clock edge that accepts the last one, `running` drops to 0 and `done` is set.
- R7: In autobuffer mode (`cfgAuto`=1), the address that follows the last one is the latched start address. `done` is set at that edge and `running` stays 1.
- R8: A zero value in `cfgXCount` or `cfgYCount` at the start edge sets `error`, and no address is issued.
- R9: A start address that is misaligned sets `error`, and no address is issued. With `cfgWide`=0 (16-bit elements) bit 0 must be 0. With `cfgWide`=1 (32-bit elements) bits 1:0 must be 0.
- R10: While `enable` is 0, `addrValid` is 0. `running` falls at the next edge, and `done` is not set.
- R11: `done` and `error` keep their value until a 1 on `clrDone` or `clrError`, respectively, clears them at a clock edge.
- R12: Changes to `cfgStart`, `cfgXModify` or `cfgYModify` after the start edge do not affect the running transfer, including the autobuffer wrap.
- R13: When `enable` is held high after a stop-mode transfer ends, no new transfer starts. A new transfer needs another rising edge of `enable`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgStart | input | 32 | Start byte address |
| cfgXCount | input | 16 | Elements per row |
| cfgXModify | input | 16 | Signed byte stride inside a row |
| cfgYCount | input | 16 | Number of rows |
| cfgYModify | input | 16 | Signed byte stride from a row's last element to the next row's first |
| cfgWide | input | 1 | Element size: 0 selects 16 bits, 1 selects 32 bits |
| cfgAuto | input | 1 | 1 selects autobuffer mode, 0 selects stop mode |
| enable | input | 1 | Rising edge starts a transfer; low halts it |
| clrDone | input | 1 | Clears `done` |
| clrError | input | 1 | Clears `error` |
| addrValid | output | 1 | An address is offered |
| addrReady | input | 1 | Consumer accepts the offered address |
| addrOut | output | 32 | Offered byte address |
| running | output | 1 | Transfer active |
| done | output | 1 | Sticky end-of-transfer flag |
| error | output | 1 | Sticky configuration-error flag |

## Verification
Some properties hold on every cycle, and the assertions check those: the address stays steady under backpressure, a valid address is offered only while running, the flags stay set until cleared, `done` only rises on an accepted handshake, `enable` low always silences the port, and the controller never raises two datapath strobes at once.

The actual address values need the bench's scenarios. That covers the stride arithmetic with negative strides and 32-bit wraparound, the row-to-row switch to the outer stride, the exact element count, the autobuffer return to a start address that has since been changed at the inputs, and the rejection of zero counts and misaligned starts.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;
  localparam int ADDR_W = 32;
  localparam int CNT_W  = 16;
  localparam int MOD_W  = 16;

  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} gen_state_t;

  // Strobes from control to datapath; at most one is high per cycle.
  typedef struct packed {
    logic loadCfg;   // copy config, point at start
    logic rewind;    // return to latched start (autobuffer)
    logic stepX;     // advance by inner stride
    logic stepY;     // advance by outer stride
  } dp_strobe_t;
endpackage

// File: rtl/dma2d_datapath.sv
module dma2d_datapath
  import dma2d_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int MW = MOD_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  dp_strobe_t    strobe,
  input  logic [AW-1:0] startIn,
  input  logic [MW-1:0] xModIn,
  input  logic [MW-1:0] yModIn,
  output logic [AW-1:0] addr
);
  localparam int EXT_W = AW - MW;

  logic [AW-1:0] startLat;
  logic [MW-1:0] xModLat;
  logic [MW-1:0] yModLat;
  logic [AW-1:0] strideSel;

  always_comb begin
    if (strobe.stepY) strideSel = {{EXT_W{yModLat[MW-1]}}, yModLat};
    else              strideSel = {{EXT_W{xModLat[MW-1]}}, xModLat};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startLat <= '0;
      xModLat  <= '0;
      yModLat  <= '0;
      addr     <= '0;
    end else begin
      if (strobe.loadCfg) begin
        startLat <= startIn;
        xModLat  <= xModIn;
        yModLat  <= yModIn;
        addr     <= startIn;
      end else if (strobe.rewind) begin
        addr <= startLat;
      end else if (strobe.stepX || strobe.stepY) begin
        addr <= addr + strideSel;
      end
    end
  end
endmodule

// File: rtl/dma2d_ctrl.sv
module dma2d_ctrl
  import dma2d_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [CW-1:0] xCountIn,
  input  logic [CW-1:0] yCountIn,
  input  logic [1:0]    startLow,
  input  logic          wideIn,
  input  logic          autoIn,
  input  logic          enable,
  input  logic          clrDone,
  input  logic          clrError,
  input  logic          addrReady,
  output logic          addrValid,
  output logic          running,
  output logic          done,
  output logic          error,
  output dp_strobe_t    strobe
);
  gen_state_t state;
  logic          enPrev;
  logic          autoLat;
  logic [CW-1:0] xLat;
  logic [CW-1:0] xRem;
  logic [CW-1:0] yLat;
  logic [CW-1:0] yRem;

  logic startReq, cfgBad, misaligned, fire, lastCol, lastRow, passEnd;

  assign misaligned = wideIn ? (startLow != 2'b00) : startLow[0];
  assign cfgBad     = (xCountIn == '0) || (yCountIn == '0) || misaligned;
  assign startReq   = enable && !enPrev && (state == ST_IDLE);
  assign addrValid  = (state == ST_RUN) && enable;
  assign running    = (state == ST_RUN);
  assign fire       = addrValid && addrReady;
  assign lastCol    = (xRem == CW'(1));
  assign lastRow    = (yRem == CW'(1));
  assign passEnd    = fire && lastCol && lastRow;

  always_comb begin
    strobe         = '0;
    strobe.loadCfg = startReq && !cfgBad;
    strobe.stepX   = fire && !lastCol;
    strobe.stepY   = fire && lastCol && !lastRow;
    strobe.rewind  = passEnd && autoLat;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      enPrev  <= 1'b0;
      autoLat <= 1'b0;
      xLat    <= '0;
      yLat    <= '0;
      xRem    <= '0;
      yRem    <= '0;
      done    <= 1'b0;
      error   <= 1'b0;
    end else begin
      enPrev <= enable;

      if (strobe.loadCfg) begin
        state   <= ST_RUN;
        autoLat <= autoIn;
        xLat    <= xCountIn;
        yLat    <= yCountIn;
        xRem    <= xCountIn;
        yRem    <= yCountIn;
      end else if (state == ST_RUN) begin
        if (!enable) begin
          state <= ST_IDLE;
        end else if (passEnd) begin
          xRem <= xLat;
          yRem <= yLat;
          if (!autoLat) state <= ST_IDLE;
        end else if (strobe.stepY) begin
          xRem <= xLat;
          yRem <= yRem - CW'(1);
        end else if (strobe.stepX) begin
          xRem <= xRem - CW'(1);
        end
      end

      if (passEnd)       done <= 1'b1;
      else if (clrDone)  done <= 1'b0;

      if (startReq && cfgBad) error <= 1'b1;
      else if (clrError)      error <= 1'b0;
    end
  end
endmodule

// File: rtl/dma2d_addr_gen.sv
module dma2d_addr_gen
  import dma2d_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [31:0] cfgStart,
  input  logic [15:0] cfgXCount,
  input  logic [15:0] cfgXModify,
  input  logic [15:0] cfgYCount,
  input  logic [15:0] cfgYModify,
  input  logic        cfgWide,
  input  logic        cfgAuto,
  input  logic        enable,
  input  logic        clrDone,
  input  logic        clrError,
  output logic        addrValid,
  input  logic        addrReady,
  output logic [31:0] addrOut,
  output logic        running,
  output logic        done,
  output logic        error
);
  dp_strobe_t strobe;

  dma2d_ctrl #(.CW(CNT_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .xCountIn  (cfgXCount),
    .yCountIn  (cfgYCount),
    .startLow  (cfgStart[1:0]),
    .wideIn    (cfgWide),
    .autoIn    (cfgAuto),
    .enable    (enable),
    .clrDone   (clrDone),
    .clrError  (clrError),
    .addrReady (addrReady),
    .addrValid (addrValid),
    .running   (running),
    .done      (done),
    .error     (error),
    .strobe    (strobe)
  );

  dma2d_datapath #(.AW(ADDR_W), .MW(MOD_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .startIn (cfgStart),
    .xModIn  (cfgXModify),
    .yModIn  (cfgYModify),
    .addr    (addrOut)
  );
endmodule

// File: rtl/dma2d_addr_gen_chk.sv
module dma2d_addr_gen_chk
  import dma2d_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        enable,
  input logic        clrDone,
  input logic        clrError,
  input logic        addrValid,
  input logic        addrReady,
  input logic [31:0] addrOut,
  input logic        running,
  input logic        done,
  input logic        error,
  input dp_strobe_t  strobe
);
  assert_valid_needs_run_R2: assert property (@(posedge clk) disable iff (!rstN)
    addrValid |-> running);

  assert_hold_addr_R5: assert property (@(posedge clk) disable iff (!rstN)
    (addrValid && !addrReady) |=> $stable(addrOut));

  assert_done_on_accept_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(addrValid && addrReady));

  assert_error_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(error) |-> !running);

  assert_halt_silent_R10: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> !addrValid);

  assert_halt_stops_R10: assert property (@(posedge clk) disable iff (!rstN)
    (running && !enable) |=> !running);

  assert_done_sticky_R11: assert property (@(posedge clk) disable iff (!rstN)
    (done && !clrDone) |=> done);

  assert_error_sticky_R11: assert property (@(posedge clk) disable iff (!rstN)
    (error && !clrError) |=> error);

  assert_one_strobe_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.loadCfg, strobe.rewind, strobe.stepX, strobe.stepY}));
endmodule

bind dma2d_addr_gen dma2d_addr_gen_chk u_chk (.*);

// File: tb/dma2d_addr_gen_tb.sv
module dma2d_addr_gen_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] cfgStart = '0;
  logic [15:0] cfgXCount = '0, cfgXModify = '0, cfgYCount = '0, cfgYModify = '0;
  logic        cfgWide = 1'b0, cfgAuto = 1'b0;
  logic        enable = 1'b0, clrDone = 1'b0, clrError = 1'b0, addrReady = 1'b0;
  logic        addrValid, running, done, error;
  logic [31:0] addrOut;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  dma2d_addr_gen u_dut (.*);

  typedef struct packed {
    logic [31:0] start;
    logic [15:0] xc;
    logic [15:0] xm;
    logic [15:0] yc;
    logic [15:0] ym;
    logic        wide;
    logic        expErr;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{32'h0000_1000, 16'd4, 16'd2,      16'd3, 16'd2,      1'b0, 1'b0}, // linear
    '{32'h0000_2000, 16'd3, 16'd4,      16'd2, 16'hFFF8,   1'b1, 1'b0}, // negative outer
    '{32'hFFFF_FFF8, 16'd3, 16'd4,      16'd2, 16'd4,      1'b1, 1'b0}, // 2^32 wrap
    '{32'h0000_0100, 16'd2, 16'd2,      16'd3, 16'd18,     1'b0, 1'b0}, // window, pitch 20
    '{32'h0000_0300, 16'd4, 16'hFFFE,   16'd2, 16'd12,     1'b0, 1'b0}, // negative inner
    '{32'h0000_1000, 16'd0, 16'd2,      16'd3, 16'd2,      1'b0, 1'b1}, // zero X
    '{32'h0000_1000, 16'd3, 16'd2,      16'd0, 16'd2,      1'b0, 1'b1}, // zero Y
    '{32'h0000_1002, 16'd2, 16'd4,      16'd2, 16'd4,      1'b1, 1'b1}, // misaligned 32
    '{32'h0000_1001, 16'd2, 16'd2,      16'd2, 16'd2,      1'b0, 1'b1}  // misaligned 16
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] sext(input logic [15:0] m);
    return {{16{m[15]}}, m};
  endfunction

  task automatic setCfg(input logic [31:0] s, input logic [15:0] xc, input logic [15:0] xm,
                        input logic [15:0] yc, input logic [15:0] ym,
                        input logic w, input logic au);
    cfgStart = s; cfgXCount = xc; cfgXModify = xm;
    cfgYCount = yc; cfgYModify = ym; cfgWide = w; cfgAuto = au;
  endtask

  // Clear flags and drop enable, then raise enable. Returns at the negedge
  // after the start edge.
  task automatic kick();
    @(negedge clk); enable = 1'b0; clrDone = 1'b1; clrError = 1'b1;
    @(negedge clk); clrDone = 1'b0; clrError = 1'b0; enable = 1'b1;
    @(negedge clk);
  endtask

  task automatic runVec(input vec_t v);
    logic [31:0] exp;
    setCfg(v.start, v.xc, v.xm, v.yc, v.ym, v.wide, 1'b0);
    addrReady = 1'b1;
    kick();
    if (v.expErr) begin
      check(v.xc == 0 || v.yc == 0 ? "R8 error" : "R9 error", {31'b0, error}, 32'd1);
      check("R8/R9 no address R8 R9", {31'b0, addrValid}, 32'd0);
      check("R8 not running", {31'b0, running}, 32'd0);
      return;
    end
    check("R2 running", {31'b0, running}, 32'd1);
    exp = v.start;
    for (int y = 0; y < int'(v.yc); y++) begin
      for (int x = 0; x < int'(v.xc); x++) begin
        check("R3/R4 valid R3", {31'b0, addrValid}, 32'd1);
        check((x == 0 && y > 0) ? "R4 row step" : "R3 element step", addrOut, exp);
        exp = exp + ((x == int'(v.xc) - 1) ? sext(v.ym) : sext(v.xm));
        @(negedge clk);
      end
    end
    check("R6 stopped", {31'b0, running}, 32'd0);
    check("R6 done", {31'b0, done}, 32'd1);
    check("R6 no extra address", {31'b0, addrValid}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] exp;
    // R1 reset state
    @(negedge clk);
    check("R1 valid", {31'b0, addrValid}, 32'd0);
    check("R1 running", {31'b0, running}, 32'd0);
    check("R1 done", {31'b0, done}, 32'd0);
    check("R1 error", {31'b0, error}, 32'd0);
    @(negedge clk); rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) runVec(VECS[i]);

    // R11 error clears on its pulse
    setCfg(32'h10, 16'd0, 16'd2, 16'd1, 16'd2, 1'b0, 1'b0);
    kick();
    repeat (2) @(negedge clk);
    check("R11 error held", {31'b0, error}, 32'd1);
    clrError = 1'b1; @(negedge clk); clrError = 1'b0;
    check("R11 error cleared", {31'b0, error}, 32'd0);

    // R5 backpressure, then R13 no restart while enable stays high
    setCfg(32'h200, 16'd2, 16'd2, 16'd1, 16'd2, 1'b0, 1'b0);
    addrReady = 1'b0;
    kick();
    for (int k = 0; k < 3; k++) begin
      check("R5 hold", addrOut, 32'h200);
      check("R5 valid", {31'b0, addrValid}, 32'd1);
      @(negedge clk);
    end
    addrReady = 1'b1;
    @(negedge clk);
    check("R5 after accept", addrOut, 32'h202);
    @(negedge clk);
    check("R6 done bp", {31'b0, done}, 32'd1);
    for (int k = 0; k < 4; k++) begin
      check("R13 no restart", {31'b0, addrValid | running}, 32'd0);
      @(negedge clk);
    end

    // R10 halt
    setCfg(32'h100, 16'd4, 16'd2, 16'd1, 16'd2, 1'b0, 1'b0);
    addrReady = 1'b1;
    kick();
    @(negedge clk); @(negedge clk);
    check("R10 pre-halt addr", addrOut, 32'h104);
    enable = 1'b0;
    #1 check("R10 valid drops", {31'b0, addrValid}, 32'd0);
    @(negedge clk);
    check("R10 running drops", {31'b0, running}, 32'd0);
    check("R10 no done", {31'b0, done}, 32'd0);

    // R7 autobuffer with R12 config change mid-run
    setCfg(32'h40, 16'd2, 16'd4, 16'd2, 16'd4, 1'b1, 1'b1);
    addrReady = 1'b1;
    kick();
    cfgStart = 32'h800; cfgXModify = 16'd8; cfgYModify = 16'd64;
    exp = 32'h40;
    for (int k = 0; k < 4; k++) begin
      check("R12 latched stride", addrOut, exp);
      exp = exp + 32'd4;
      @(negedge clk);
    end
    check("R7 wrap to start", addrOut, 32'h40);
    check("R7 still running", {31'b0, running}, 32'd1);
    check("R7 done per pass", {31'b0, done}, 32'd1);
    addrReady = 1'b0; clrDone = 1'b1;
    @(negedge clk); clrDone = 1'b0;
    check("R11 done cleared", {31'b0, done}, 32'd0);
    check("R7 held after wrap", addrOut, 32'h40);
    addrReady = 1'b1;
    @(negedge clk);
    check("R7 second pass step", addrOut, 32'h44);
    enable = 1'b0;
    @(negedge clk);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule